// File: doc/BRIEF.md
# Local Interrupt Acceptance and Prioritizer

This block sits beside a processor core and takes in interrupt messages, one per clock at most. Each message carries an 8-bit vector, a 3-bit delivery mode, a level/edge trigger flag and a destination, which is either a physical ID or a bitmask. Messages that reach this core either enter a 256-entry request bit vector or a one-deep slot. Fixed and lowest-priority messages go to the request bit vector. Each request bit has a trigger-mode bit beside it. System-management, non-maskable, init and external messages each go to their own one-deep slot, and the slot keeps the vector it captured.

From the stored state the block presents one interrupt to the core. The core sees a pending flag, the kind and vector of the interrupt to take, and the trigger mode of a presented fixed vector. A separate flag reports that an unmaskable kind is waiting. A one-cycle acknowledge retires the presented interrupt.

Top module: `lirq_prioritizer`

## Requirements
- R1: After reset, intPending, intKind, intVector, intLevel and unmaskPending are all 0.
- R2: A message is taken only when (msgDestLogical is 0 and msgDest equals localId) or (localId is below 8 and bit localId of msgDest is 1). Any other message changes nothing.
- R3: Mode codes 000 (fixed) and 001 (lowest priority) set the request bit indexed by msgVector. Other codes never touch the request bits.
- R4: When a request bit goes from 0 to 1, its trigger bit takes msgLevel. A message whose request bit is already set changes neither bit. intLevel shows the trigger bit of a presented fixed vector and is 0 for every other kind.
- R5: When no slot is pending and at least one request bit is set, intKind is 1 and intVector is the highest set request index.
- R6: Code 010 loads the SMI slot, 100 the NMI slot, 101 the INIT slot and 111 the external slot, capturing msgVector. A message for a slot that is already full is dropped, and the stored vector stays.
- R7: unmaskPending is 1 exactly when the SMI, NMI or INIT slot is full. The external slot does not affect it.
- R8: Codes 011 and 110 are reserved, and messages carrying them change no state.
- R9: The presented interrupt follows the order SMI (kind 5), NMI (kind 4), INIT (kind 3), external (kind 2), fixed (kind 1). With nothing pending, intKind is 0 and intVector is 0.
- R10: ackIn retires the presented interrupt: it empties the presented slot, or clears the presented request bit. The next-highest request then becomes visible one cycle later. ackIn has no effect while nothing is pending.
- R11: When an acknowledge and a message arrive in the same cycle, the acknowledge is applied first. A message for the kind just retired is therefore accepted as new.
- R12: intPending is 1 whenever any slot or any request bit is set, one cycle after the message that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localId | input | 8 | Identity of this core |
| msgValid | input | 1 | Message present this cycle |
| msgVector | input | 8 | Message vector |
| msgMode | input | 3 | Delivery mode code |
| msgLevel | input | 1 | 1 for level-triggered, 0 for edge-triggered |
| msgDestLogical | input | 1 | 1 selects bitmask destination |
| msgDest | input | 8 | Destination ID or bitmask |
| ackIn | input | 1 | Retire the presented interrupt |
| intPending | output | 1 | Some interrupt waits |
| intKind | output | 3 | Kind of the presented interrupt |
| intVector | output | 8 | Vector of the presented interrupt |
| intLevel | output | 1 | Trigger mode of the presented fixed vector |
| unmaskPending | output | 1 | An SMI, NMI or INIT slot is full |

## Verification
The hardest cases to reach from the ports need several things pending at once while messages collide with acknowledges. Two examples are a full slot receiving a second message in the very cycle it is retired, and a fixed vector re-arriving with the opposite trigger mode just as it is acknowledged. Directed phases stack all four slots on top of several request bits and then drain them in order, with re-arrivals timed to the acknowledge. A long random phase follows. It restricts vectors to a small set so that duplicates and same-cycle collisions happen often, while a behavioural model is compared on every cycle.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int SLOT_SMI  = 0;
  localparam int SLOT_NMI  = 1;
  localparam int SLOT_INIT = 2;
  localparam int SLOT_EXT  = 3;
  localparam int NUM_SLOTS = 4;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_FIXED = 3'd1,
    KIND_EXT   = 3'd2,
    KIND_INIT  = 3'd3,
    KIND_NMI   = 3'd4,
    KIND_SMI   = 3'd5
  } kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 acceptFixed;
    logic                 ackFixed;
    logic [NUM_SLOTS-1:0] slotSet;
    logic [NUM_SLOTS-1:0] slotClr;
  } strobe_t;
endpackage

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
  import lirq_pkg::*;
#(
  parameter int DEST_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DEST_W-1:0]    localId,
  input  logic                 msgValid,
  input  logic [2:0]           msgMode,
  input  logic                 msgDestLogical,
  input  logic [DEST_W-1:0]    msgDest,
  input  logic                 ackIn,
  input  logic [NUM_SLOTS-1:0] slotPend,
  input  logic                 reqAny,
  output strobe_t              st,
  output kind_e                curKind
);
  localparam int IDX_W = (DEST_W > 1) ? $clog2(DEST_W) : 1;

  logic physHit, maskHit, destHit;

  // R2: destination filter
  always_comb begin
    physHit = !msgDestLogical && (msgDest == localId);
    maskHit = (int'(localId) < DEST_W) && msgDest[localId[IDX_W-1:0]];
    destHit = msgValid && (physHit || maskHit);
  end

  // R9: fixed precedence among pending sources
  always_comb begin
    if (slotPend[SLOT_SMI])       curKind = KIND_SMI;
    else if (slotPend[SLOT_NMI])  curKind = KIND_NMI;
    else if (slotPend[SLOT_INIT]) curKind = KIND_INIT;
    else if (slotPend[SLOT_EXT])  curKind = KIND_EXT;
    else if (reqAny)              curKind = KIND_FIXED;
    else                          curKind = KIND_NONE;
  end

  always_comb begin
    st = '0;
    if (destHit) begin
      case (msgMode)
        3'b000, 3'b001: st.acceptFixed = 1'b1;
        3'b010:         st.slotSet[SLOT_SMI]  = 1'b1;
        3'b100:         st.slotSet[SLOT_NMI]  = 1'b1;
        3'b101:         st.slotSet[SLOT_INIT] = 1'b1;
        3'b111:         st.slotSet[SLOT_EXT]  = 1'b1;
        default:        ;  // R8: reserved codes
      endcase
    end
    if (ackIn) begin
      case (curKind)
        KIND_SMI:   st.slotClr[SLOT_SMI]  = 1'b1;
        KIND_NMI:   st.slotClr[SLOT_NMI]  = 1'b1;
        KIND_INIT:  st.slotClr[SLOT_INIT] = 1'b1;
        KIND_EXT:   st.slotClr[SLOT_EXT]  = 1'b1;
        KIND_FIXED: st.ackFixed = 1'b1;
        default:    ;
      endcase
    end
  end

  a_r8_reserved_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && (msgMode == 3'b011 || msgMode == 3'b110)) |-> (!st.acceptFixed && st.slotSet == '0));

  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && (reqAny || (|slotPend))) |-> $onehot({st.ackFixed, st.slotClr}));

  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !reqAny && slotPend == '0) |-> (!st.ackFixed && st.slotClr == '0));

  a_r9_smi_first: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && slotPend[SLOT_SMI]) |-> (st.slotClr == 4'b0001 && !st.ackFixed));
endmodule

// File: rtl/lirq_dp.sv
module lirq_dp
  import lirq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         st,
  input  logic [VEC_W-1:0]                msgVector,
  input  logic                            msgLevel,
  output logic [NUM_SLOTS-1:0]            slotPend,
  output logic [NUM_SLOTS-1:0][VEC_W-1:0] slotVec,
  output logic                            reqAny,
  output logic [VEC_W-1:0]                hiVec,
  output logic                            hiLevel,
  output logic                            unmask
);
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int LO_W    = VEC_W / 2;
  localparam int HI_W    = VEC_W - LO_W;
  localparam int GRP     = 1 << LO_W;
  localparam int NUM_GRP = 1 << HI_W;

  logic [NUM_VEC-1:0] reqBits, trigBits, reqAfter, ackMask, setMask;
  logic               newBit;
  logic [VEC_W-1:0]   encVec, hiBase, hiNext;
  logic [NUM_GRP-1:0] grpAny;
  logic [LO_W-1:0]    grpIdx [NUM_GRP];

  // ack is applied before the incoming message (R11)
  always_comb begin
    ackMask  = st.ackFixed ? ({{(NUM_VEC-1){1'b0}}, 1'b1} << hiVec) : '0;
    setMask  = st.acceptFixed ? ({{(NUM_VEC-1){1'b0}}, 1'b1} << msgVector) : '0;
    reqAfter = reqBits & ~ackMask;
    newBit   = st.acceptFixed && !reqAfter[msgVector];
  end

  // two-level priority encoder over the surviving request bits
  for (genvar g = 0; g < NUM_GRP; g++) begin : gEnc
    logic [LO_W-1:0] idx;
    always_comb begin
      idx = '0;
      for (int b = 0; b < GRP; b++)
        if (reqAfter[g*GRP + b]) idx = b[LO_W-1:0];
    end
    assign grpAny[g] = |reqAfter[g*GRP +: GRP];
    assign grpIdx[g] = idx;
  end

  always_comb begin
    encVec = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (grpAny[g]) encVec = {g[HI_W-1:0], grpIdx[g]};
  end

  // R5: highest-vector register, raised by arrivals, rescanned on ack
  always_comb begin
    hiBase = st.ackFixed ? encVec : hiVec;
    hiNext = (st.acceptFixed && (msgVector > hiBase)) ? msgVector : hiBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBits  <= '0;
      trigBits <= '0;
      hiVec    <= '0;
    end else begin
      reqBits <= reqAfter | setMask;
      hiVec   <= hiNext;
      if (newBit) trigBits[msgVector] <= msgLevel;  // R4
    end
  end

  assign reqAny  = |reqBits;
  assign hiLevel = trigBits[hiVec];

  // R6: one-deep slots
  logic [NUM_SLOTS-1:0] pendKeep, pendNext, loadVec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    always_comb begin
      pendKeep[i] = slotPend[i] & ~st.slotClr[i];
      loadVec[i]  = st.slotSet[i] & ~pendKeep[i];
      pendNext[i] = pendKeep[i] | st.slotSet[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotPend[i] <= 1'b0;
        slotVec[i]  <= '0;
      end else begin
        slotPend[i] <= pendNext[i];
        if (loadVec[i]) slotVec[i] <= msgVector;
      end
    end

    a_r6_vec_held: assert property (@(posedge clk) disable iff (!rstN)
      (slotPend[i] && !st.slotClr[i]) |=> $stable(slotVec[i]));
  end

  // R7: shared unmaskable flag
  always_ff @(posedge clk) begin
    if (!rstN) unmask <= 1'b0;
    else       unmask <= pendNext[SLOT_SMI] | pendNext[SLOT_NMI] | pendNext[SLOT_INIT];
  end

  a_r5_top_is_set: assert property (@(posedge clk) disable iff (!rstN)
    reqAny |-> reqBits[hiVec]);

  a_r5_none_above: assert property (@(posedge clk) disable iff (!rstN)
    reqAny |-> ((reqBits >> hiVec) == {{(NUM_VEC-1){1'b0}}, 1'b1}));

  a_r4_trig_kept: assert property (@(posedge clk) disable iff (!rstN)
    (st.acceptFixed && reqBits[msgVector] && !st.ackFixed) |=> $stable(trigBits));

  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!st.acceptFixed && !st.ackFixed && st.slotSet == '0 && st.slotClr == '0)
      |=> ($stable(reqBits) && $stable(slotPend)));
endmodule

// File: rtl/lirq_prioritizer.sv
module lirq_prioritizer
  import lirq_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEST_W-1:0] localId,
  input  logic              msgValid,
  input  logic [VEC_W-1:0]  msgVector,
  input  logic [2:0]        msgMode,
  input  logic              msgLevel,
  input  logic              msgDestLogical,
  input  logic [DEST_W-1:0] msgDest,
  input  logic              ackIn,
  output logic              intPending,
  output logic [2:0]        intKind,
  output logic [VEC_W-1:0]  intVector,
  output logic              intLevel,
  output logic              unmaskPending
);
  strobe_t                         st;
  kind_e                           curKind;
  logic [NUM_SLOTS-1:0]            slotPend;
  logic [NUM_SLOTS-1:0][VEC_W-1:0] slotVec;
  logic                            reqAny, hiLevel, unmask;
  logic [VEC_W-1:0]                hiVec;

  lirq_ctrl #(.DEST_W(DEST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .localId(localId), .msgValid(msgValid),
    .msgMode(msgMode), .msgDestLogical(msgDestLogical), .msgDest(msgDest),
    .ackIn(ackIn), .slotPend(slotPend), .reqAny(reqAny),
    .st(st), .curKind(curKind)
  );

  lirq_dp #(.VEC_W(VEC_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .msgVector(msgVector), .msgLevel(msgLevel),
    .slotPend(slotPend), .slotVec(slotVec), .reqAny(reqAny),
    .hiVec(hiVec), .hiLevel(hiLevel), .unmask(unmask)
  );

  always_comb begin
    case (curKind)
      KIND_SMI:   intVector = slotVec[SLOT_SMI];
      KIND_NMI:   intVector = slotVec[SLOT_NMI];
      KIND_INIT:  intVector = slotVec[SLOT_INIT];
      KIND_EXT:   intVector = slotVec[SLOT_EXT];
      KIND_FIXED: intVector = hiVec;
      default:    intVector = '0;
    endcase
  end

  assign intKind       = curKind;
  assign intLevel      = (curKind == KIND_FIXED) && hiLevel;
  assign intPending    = reqAny || (|slotPend);
  assign unmaskPending = unmask;

  a_r7_unmask_needs_slot: assert property (@(posedge clk) disable iff (!rstN)
    unmaskPending |-> (intKind == 3'd5 || intKind == 3'd4 || intKind == 3'd3));

  a_r12_kind_iff_pending: assert property (@(posedge clk) disable iff (!rstN)
    intPending == (intKind != 3'd0));
endmodule

// File: tb/tb_lirq_prioritizer.sv
module tb_lirq_prioritizer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] localId = 8'd3;
  logic       msgValid = 1'b0;
  logic [7:0] msgVector = '0;
  logic [2:0] msgMode = '0;
  logic       msgLevel = 1'b0;
  logic       msgDestLogical = 1'b0;
  logic [7:0] msgDest = '0;
  logic       ackIn = 1'b0;
  logic       intPending, intLevel, unmaskPending;
  logic [2:0] intKind;
  logic [7:0] intVector;

  always #4 clk = ~clk;  // 125 MHz

  lirq_prioritizer dut (
    .clk(clk), .rstN(rstN), .localId(localId), .msgValid(msgValid),
    .msgVector(msgVector), .msgMode(msgMode), .msgLevel(msgLevel),
    .msgDestLogical(msgDestLogical), .msgDest(msgDest), .ackIn(ackIn),
    .intPending(intPending), .intKind(intKind), .intVector(intVector),
    .intLevel(intLevel), .unmaskPending(unmaskPending)
  );

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference: slot 0 SMI, 1 NMI, 2 INIT, 3 EXT
  bit       mReq [256];
  bit       mTrig[256];
  bit       mPend[4];
  bit [7:0] mVec [4];

  function automatic int topReq();
    int t = -1;
    foreach (mReq[i]) if (mReq[i]) t = i;
    return t;
  endfunction

  function automatic int expKind();
    if (mPend[0]) return 5;
    if (mPend[1]) return 4;
    if (mPend[2]) return 3;
    if (mPend[3]) return 2;
    if (topReq() >= 0) return 1;
    return 0;
  endfunction

  task automatic cmp(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkOutputs();
    int k = expKind();
    int v = 0;
    int lv = 0;
    case (k)
      5: v = mVec[0];
      4: v = mVec[1];
      3: v = mVec[2];
      2: v = mVec[3];
      1: begin v = topReq(); lv = mTrig[v]; end
      default: v = 0;
    endcase
    cmp("kind", int'(intKind), k);
    cmp("vector", int'(intVector), v);
    cmp("level", int'(intLevel), lv);
    cmp("pending", int'(intPending), int'(k != 0));
    cmp("unmask", int'(unmaskPending), int'(mPend[0] | mPend[1] | mPend[2]));
  endtask

  task automatic modelStep(bit v, bit [2:0] md, bit [7:0] vec, bit lvl, bit lg, bit [7:0] dst, bit ak);
    int k = expKind();
    bit hit;
    if (ak) begin
      case (k)
        5: mPend[0] = 0;
        4: mPend[1] = 0;
        3: mPend[2] = 0;
        2: mPend[3] = 0;
        1: mReq[topReq()] = 0;
        default: ;
      endcase
    end
    hit = v && ((!lg && dst == localId) || (localId < 8 && dst[localId[2:0]]));
    if (hit) begin
      int s = -1;
      case (md)
        3'b010: s = 0;
        3'b100: s = 1;
        3'b101: s = 2;
        3'b111: s = 3;
        default: s = -1;
      endcase
      if (md == 3'b000 || md == 3'b001) begin
        if (!mReq[vec]) begin mReq[vec] = 1; mTrig[vec] = lvl; end
      end else if (s >= 0 && !mPend[s]) begin
        mPend[s] = 1;
        mVec[s] = vec;
      end
    end
  endtask

  // one clock: check the state, then present inputs for the next edge
  task automatic step(bit v, bit [2:0] md, bit [7:0] vec, bit lvl, bit lg, bit [7:0] dst, bit ak);
    @(negedge clk);
    checkOutputs();
    msgValid = v; msgMode = md; msgVector = vec; msgLevel = lvl;
    msgDestLogical = lg; msgDest = dst; ackIn = ak;
    modelStep(v, md, vec, lvl, lg, dst, ak);
  endtask

  task automatic send(bit [2:0] md, bit [7:0] vec, bit lvl);
    step(1, md, vec, lvl, 0, localId, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ack();
    step(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && expKind() != 0; i++) ack();
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state, checked while reset is held and just after release
    repeat (3) @(posedge clk);
    @(negedge clk); checkOutputs();
    rstN = 1'b1;
    idle(2);

    // R3 and R4: fixed and lowest-priority arrivals with trigger capture
    tag = "R3";
    send(3'b000, 8'd5, 0);
    send(3'b001, 8'd200, 1);
    idle(1);
    tag = "R4";
    send(3'b000, 8'd200, 0);  // already set: trigger stays level
    send(3'b001, 8'd5, 1);    // already set: trigger stays edge
    idle(1);
    tag = "R10";
    ack(); idle(1);           // 200 retired, 5 (edge) shows
    tag = "R4";
    send(3'b000, 8'd200, 0);  // re-arrival after clearing takes new mode
    idle(1);
    tag = "R10";
    drain();

    // R5: highest index wins regardless of order, including 0 and 255
    tag = "R5";
    send(3'b000, 8'd0, 0);
    send(3'b000, 8'd77, 1);
    send(3'b000, 8'd255, 0);
    send(3'b001, 8'd16, 1);
    send(3'b000, 8'd15, 0);
    idle(1);
    for (int i = 0; i < 6; i++) ack();
    idle(1);

    // R2: destination filtering
    tag = "R2";
    step(1, 3'b000, 8'd40, 0, 0, 8'd4, 0);        // wrong physical id
    step(1, 3'b000, 8'd41, 0, 1, 8'd3, 0);        // mask 0x03 lacks bit 3
    step(1, 3'b000, 8'd42, 1, 1, 8'b0000_1000, 0); // mask hit
    step(1, 3'b000, 8'd43, 0, 0, 8'b0000_1000, 0); // bit 3 set in physical mode
    idle(1);
    drain();

    // R8: reserved codes leave everything unchanged
    tag = "R8";
    send(3'b011, 8'd9, 1);
    send(3'b110, 8'd10, 0);
    idle(2);

    // R6 and R7: slot capture, drop and shared flag
    tag = "R6";
    send(3'b010, 8'h11, 0);
    send(3'b010, 8'h22, 0);   // dropped, 0x11 kept
    idle(1);
    tag = "R7";
    ack();
    send(3'b111, 8'h33, 0);   // external alone: unmask stays 0
    idle(1);
    send(3'b111, 8'h44, 0);   // dropped
    idle(1);
    drain();

    // R9: full stack, drained in precedence order
    tag = "R9";
    send(3'b000, 8'd90, 1);
    send(3'b111, 8'h70, 0);
    send(3'b101, 8'h60, 0);
    send(3'b100, 8'h50, 0);
    send(3'b010, 8'h40, 0);
    idle(1);
    for (int i = 0; i < 6; i++) ack();
    idle(1);

    // R11: ack and re-arrival in the same cycle
    tag = "R11";
    send(3'b100, 8'h01, 0);
    idle(1);
    step(1, 3'b100, 8'h02, 0, 0, localId, 1);  // NMI retired and refilled with 0x02
    idle(1);
    ack();
    send(3'b000, 8'd120, 1);
    idle(1);
    step(1, 3'b000, 8'd120, 0, 0, localId, 1); // now edge
    idle(1);
    drain();

    // R10: ack with nothing pending
    tag = "R10";
    ack(); ack(); idle(1);

    // R12: mixed random traffic on a small vector set
    tag = "R12";
    for (int i = 0; i < 4000; i++) begin
      bit [7:0] d = ($urandom_range(0, 3) != 0) ? localId : 8'($urandom);
      bit [7:0] vv = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 7)) : 8'($urandom);
      step($urandom_range(0, 1), 3'($urandom), vv, 1'($urandom), 1'($urandom), d,
           ($urandom_range(0, 9) < 3));
    end
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule